// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose input pins and raises one combined interrupt when any of them sees an event of the kind software has asked for. Every pin has its own control word. A 4-bit field in that word chooses how the pin is watched: not at all, while it sits low, while it sits high, on a rising edge, on a falling edge, or on either edge.

Pin inputs first pass through a synchronizer. Edges are found by comparing each synchronized value with its value one cycle earlier. Each detected event latches a flag in a shared status word. Software reads this word to find which pins fired and clears flags by writing ones to them.

The interrupt output is a flop that is high whenever any flag is held. Access goes through a simple single-cycle register port: a write strobe with address and data, and a read-data output that follows the address combinationally.

Top module: `gpio_irq_detect`

## Requirements
- R1: The control word of pin n (n = 0 to 31) sits at byte address n*4. It reads back exactly the last 32-bit value written to it. All control words and the status word read zero after reset, and the interrupt output is low after reset.
- R2: The mode field is bits 19:16 of a control word. Codes 0x0 and every code not listed in R3 to R7 (for example 0x5, or the whole word written to zero) never set that pin's flag, whatever the pin does.
- R3: Mode 0x9 sets the pin's flag on a 0-to-1 transition of the synchronized pin. It does not set the flag on a 1-to-0 transition.
- R4: Mode 0xA sets the pin's flag on a 1-to-0 transition. It does not set the flag on a 0-to-1 transition.
- R5: Mode 0xB sets the pin's flag on both transitions.
- R6: Mode 0x8 sets the flag on every cycle while the synchronized pin is 0. A clear written while the pin stays low has no lasting effect. A clear written after the pin returns high removes the flag for good.
- R7: Mode 0xC sets the flag on every cycle while the synchronized pin is 1. A clear only lasts once the pin has returned low.
- R8: The status word is at byte address 0xA0, with bit n holding the flag of pin n. Writing a 1 to a bit clears that flag. Writing 0 leaves a flag unchanged. Writing all ones clears every flag. Flags never clear in any other way.
- R9: When a new event and a clear of the same pin fall in the same cycle, the flag stays set.
- R10: The interrupt output is a registered signal. It is high exactly when the status word is nonzero, and it updates on the same clock edge as the status word.
- R11: With the default two-stage synchronizer, a pin change made before clock edge k shows in the status word after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_in | input | 32 | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` |
| irq_out | output | 1 | Combined interrupt, high while any flag is set |

## Verification
The hardest case to reach from the ports is a clear that lands in the very cycle an edge event is detected. Only then does the priority between clearing and setting decide the outcome. To reach it, the bench counts the synchronizer and edge-compare registers from a pin change made at a known falling clock edge. It raises the clear strobe for exactly the cycle in which the event is live, then reads the flag back. The same cycle counting is used to confirm that a flag is still absent two edges after a pin change and present after the third. The level modes are also driven through a clear-while-held sequence, to show that the flag comes back until the pin level drops.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [3:0] {
      MODE_OFF  = 4'h0,
      MODE_LOW  = 4'h8,
      MODE_RISE = 4'h9,
      MODE_FALL = 4'hA,
      MODE_BOTH = 4'hB,
      MODE_HIGH = 4'hC
   } irq_mode_e;

   typedef struct packed {
      logic lvl_low;
      logic lvl_high;
      logic edge_rise;
      logic edge_fall;
   } detect_sel_t;

   function automatic detect_sel_t decode_mode(input logic [3:0] code);
      detect_sel_t s;
      s = '0;
      case (code)
         MODE_LOW:  s.lvl_low   = 1'b1;
         MODE_HIGH: s.lvl_high  = 1'b1;
         MODE_RISE: s.edge_rise = 1'b1;
         MODE_FALL: s.edge_fall = 1'b1;
         MODE_BOTH: begin
            s.edge_rise = 1'b1;
            s.edge_fall = 1'b1;
         end
         default:   s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad
      $error("gpio_irq_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
         end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
   import gpio_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level,
   input  logic [3:0] mode,
   output logic       event_o,
   output logic       active_o
);

   logic        prev_q;
   detect_sel_t sel;
   logic        rose, fell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   always_comb begin
      sel  = decode_mode(mode);
      rose = level & ~prev_q;
      fell = ~level & prev_q;
   end

   assign event_o  = (sel.lvl_low   & ~level) |
                     (sel.lvl_high  &  level) |
                     (sel.edge_rise &  rose)  |
                     (sel.edge_fall &  fell);
   assign active_o = |sel;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int               NUM_PINS    = 32,
   parameter int               DATA_W      = 32,
   parameter int               ADDR_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               MODE_LSB    = 16,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       pins_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_out
);

   localparam int CTRL_SPAN = NUM_PINS * 4;
   localparam int MODE_MSB  = MODE_LSB + 3;

   if (NUM_PINS < 1 || NUM_PINS > 32 || NUM_PINS > DATA_W) begin : g_chk_pins
      $error("gpio_irq_detect: NUM_PINS out of range");
   end
   if (MODE_MSB >= DATA_W) begin : g_chk_mode
      $error("gpio_irq_detect: mode field outside data word");
   end
   if (int'(STATUS_ADDR) < CTRL_SPAN) begin : g_chk_map
      $error("gpio_irq_detect: status word overlaps control words");
   end
   if (CTRL_SPAN > (1 << ADDR_W)) begin : g_chk_addr
      $error("gpio_irq_detect: address too narrow");
   end

   logic [NUM_PINS-1:0] level_s;
   logic [NUM_PINS-1:0] evt_vec;
   logic [NUM_PINS-1:0] active_vec;
   logic [NUM_PINS-1:0] status_q, status_nxt, clr_mask;
   logic [DATA_W-1:0]   ctrl_q [NUM_PINS];
   logic                irq_q;
   logic                status_hit;

   gpio_irq_sync #(
      .W      (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_in[NUM_PINS-1:0]),
      .q     (level_s)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_q[p] <= '0;
         else if (wr_en && addr == ADDR_W'(p * 4))
            ctrl_q[p] <= wdata;
      end

      gpio_irq_pin u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .level    (level_s[p]),
         .mode     (ctrl_q[p][MODE_MSB:MODE_LSB]),
         .event_o  (evt_vec[p]),
         .active_o (active_vec[p])
      );
   end

   if (NUM_PINS < 32) begin : g_unused_pins
      logic unused_pins;
      assign unused_pins = ^pins_in[31:NUM_PINS];
   end

   assign status_hit = (addr == STATUS_ADDR);

   always_comb begin
      clr_mask   = (wr_en && status_hit) ? wdata[NUM_PINS-1:0] : '0;
      status_nxt = (status_q & ~clr_mask) | evt_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= status_nxt;
         irq_q    <= |status_nxt;
      end
   end

   assign irq_out = irq_q;

   always_comb begin
      rdata = '0;
      if (status_hit) begin
         rdata = DATA_W'(status_q);
      end else begin
         for (int k = 0; k < NUM_PINS; k++) begin
            if (addr == ADDR_W'(k * 4)) rdata = ctrl_q[k];
         end
      end
   end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
   parameter int               NUM_PINS    = 32,
   parameter int               DATA_W      = 32,
   parameter int               ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hA0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wdata,
   input logic [DATA_W-1:0]   rdata,
   input logic                irq_out,
   input logic [NUM_PINS-1:0] status,
   input logic [NUM_PINS-1:0] evt,
   input logic [NUM_PINS-1:0] active
);

   localparam int CTRL_SPAN = NUM_PINS * 4;

   // R10: interrupt line tracks the status word
   p_irq_tracks_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (|status));

   // R8: a flag only drops when a one was written to it
   p_flag_drop_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status) & ~status) &
       ~(($past(wr_en) && $past(addr) == STATUS_ADDR) ? $past(wdata[NUM_PINS-1:0]) : '0)) == '0);

   // R9: a detected event always leaves its flag set next cycle
   p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (~status & $past(evt)) == '0);

   // R2: a flag can only rise for a pin with a valid mode
   p_no_set_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status) & ~$past(active)) == '0);

   // R1: a control write is visible on the read port the next cycle
   p_ctrl_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(addr[1:0]) == 2'b00 &&
       int'($past(addr)) < CTRL_SPAN && addr == $past(addr))
      |-> rdata == $past(wdata));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
   .NUM_PINS    (NUM_PINS),
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .STATUS_ADDR (STATUS_ADDR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .irq_out (irq_out),
   .status  (status_q),
   .evt     (evt_vec),
   .active  (active_vec)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;

   localparam logic [7:0] ST = 8'hA0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_out;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_detect u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_in (pins),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .irq_out (irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [31:0] mode_word(input logic [3:0] m);
      return {12'h000, m, 16'h0000};
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); chk("R1 reset ctrl0", d, 0);
      rd(8'h7C, d); chk("R1 reset ctrl31", d, 0);
      rd(ST, d);    chk("R1 reset status", d, 0);
      chk("R1 reset irq", {31'b0, irq_out}, 0);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      wr(8'h14, 32'hDEAD_BEEF);
      wr(8'h7C, 32'h1234_5678);
      rd(8'h14, d); chk("R1 readback ctrl5", d, 32'hDEAD_BEEF);
      rd(8'h7C, d); chk("R1 readback ctrl31", d, 32'h1234_5678);
      rd(8'h18, d); chk("R1 neighbour ctrl6 untouched", d, 0);
      wr(8'h14, 0); wr(8'h7C, 0);
   endtask

   task automatic t_rise_latency();
      logic [31:0] d;
      wr(8'h0C, mode_word(4'h9));
      settle();
      @(negedge clk); addr = ST; pins[3] = 1'b1;
      @(negedge clk); @(negedge clk);
      #1 chk("R11 not yet after two edges", {31'b0, rdata[3]}, 0);
      @(negedge clk);
      #1 chk("R11 set after third edge", {31'b0, rdata[3]}, 1);
      chk("R10 irq with flag", {31'b0, irq_out}, 1);
      wr(ST, 32'h8);
      rd(ST, d); chk("R3 cleared", d, 0);
      chk("R10 irq low after clear", {31'b0, irq_out}, 0);
      pins[3] = 1'b0; settle();
      rd(ST, d); chk("R3 falling ignored", d, 0);
      wr(8'h0C, 0);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(8'h10, mode_word(4'hA));
      pins[4] = 1'b1; settle();
      rd(ST, d); chk("R4 rising ignored", d, 0);
      pins[4] = 1'b0; settle();
      rd(ST, d); chk("R4 falling sets", d, 32'h10);
      wr(ST, 32'hFFFF_FFFF); wr(8'h10, 0);
   endtask

   task automatic t_both();
      logic [31:0] d;
      wr(8'h18, mode_word(4'hB));
      pins[6] = 1'b1; settle();
      rd(ST, d); chk("R5 rise sets", d, 32'h40);
      wr(ST, 32'h40);
      pins[6] = 1'b0; settle();
      rd(ST, d); chk("R5 fall sets", d, 32'h40);
      wr(ST, 32'h40); wr(8'h18, 0);
      rd(ST, d); chk("R5 cleared", d, 0);
   endtask

   task automatic t_low();
      logic [31:0] d;
      wr(8'h1C, mode_word(4'h8));
      settle();
      rd(ST, d); chk("R6 low level sets", d, 32'h80);
      wr(ST, 32'h80);
      rd(ST, d); chk("R6 clear while low has no lasting effect", d, 32'h80);
      pins[7] = 1'b1; settle();
      wr(ST, 32'h80);
      settle();
      rd(ST, d); chk("R6 clear after level gone", d, 0);
      pins[7] = 1'b0; wr(8'h1C, 0);
      wr(ST, 32'hFFFF_FFFF); settle();
      rd(ST, d); chk("R2 zero control word disables", d, 0);
   endtask

   task automatic t_high();
      logic [31:0] d;
      wr(8'h20, mode_word(4'hC));
      settle();
      rd(ST, d); chk("R7 low pin no flag", d, 0);
      pins[8] = 1'b1; settle();
      wr(ST, 32'h100);
      rd(ST, d); chk("R7 flag returns while high", d, 32'h100);
      pins[8] = 1'b0; settle();
      wr(ST, 32'h100); settle();
      rd(ST, d); chk("R7 clear after drop", d, 0);
      wr(8'h20, 0);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      wr(8'h24, mode_word(4'h5));
      wr(8'h28, mode_word(4'h0));
      pins[9] = 1'b1; pins[10] = 1'b1; settle();
      pins[9] = 1'b0; pins[10] = 1'b0; settle();
      rd(ST, d); chk("R2 unlisted and off modes", d, 0);
      chk("R2 irq stays low", {31'b0, irq_out}, 0);
      wr(8'h24, 0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr(8'h2C, mode_word(4'hC));
      wr(8'h30, mode_word(4'hC));
      pins[11] = 1'b1; pins[12] = 1'b1; settle();
      pins[11] = 1'b0; pins[12] = 1'b0; settle();
      wr(8'h2C, 0); wr(8'h30, 0);
      wr(ST, 32'h0);
      rd(ST, d); chk("R8 writing zero keeps flags", d, 32'h1800);
      wr(ST, 32'h800);
      rd(ST, d); chk("R8 single bit clear", d, 32'h1000);
      chk("R10 irq still high", {31'b0, irq_out}, 1);
      wr(ST, 32'hFFFF_FFFF);
      rd(ST, d); chk("R8 all ones clears", d, 0);
      chk("R10 irq dropped", {31'b0, irq_out}, 0);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      wr(8'h34, mode_word(4'h9));
      settle();
      @(negedge clk); pins[13] = 1'b1;
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; addr = ST; wdata = 32'h2000;
      @(negedge clk); wr_en = 1'b0;
      #1 chk("R9 event beats clear", rdata, 32'h2000);
      wr(ST, 32'h2000);
      rd(ST, d); chk("R9 later clear works", d, 0);
      wr(8'h34, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_readback();
      t_rise_latency();
      t_fall();
      t_both();
      t_low();
      t_high();
      t_disabled();
      t_w1c();
      t_same_cycle();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule